// File: doc/BRIEF.md
# Sparse Register-Write Stream Loader

This block builds the register image for one accelerator task from a compact byte stream. The stream is a sequence of fixed-length records. Each record names one register, or one DMA base-address slot, and carries the value or device address to place there. The stream is sparse. Any register that no record touches keeps its architectural default. For that reason the image is returned to its defaults at the start of every task, before the first record of that task is applied.

Bytes arrive one per cycle on a valid/ready interface that has an end-of-stream strobe. A task ends in one of two ways: a terminator record arrives, or the strobe is raised. When the task ends, the block pulses a completion flag. A sticky error flag reports any record that had to be dropped. After a task completes, the image can be inspected through a read port.

Top module: `regstream_loader`

## Requirements
- R1: A record is 44 bytes and every field is little-endian. Bytes 0-3 hold the count, bytes 4-7 the register address, bytes 8-15 the first value and bytes 16-23 the second value. Bytes 24-43 are padding and have no effect.
- R2: There are six group windows. Their base addresses are 0x4100, 0x4500, 0x4900, 0x4D00, 0x5100 and 0x5500, and each covers GRP_REGS (16) consecutive addresses. A record with count 1 whose address falls in a window stores bits 31:0 of the first value in that register.
- R3: The first byte accepted after reset, or after the previous task ended, starts a new task. From that point, every group register reads 0xD5F0_0000 OR its address, and every DMA base reads 0, until a record of the new task writes it.
- R4: There are seven DMA base slots, in this order: 0x1344, 0x134A, 0x1442, 0x1554, 0x1558, 0x155C, 0x1560. A record with count 1 at a slot stores the low DEV_AW (40) bits of the first value in that slot.
- R5: A record with count 2 at a slot stores the first value in that slot and the second value in the next slot of the R4 order. A record with count 2 is dropped if it targets slot 0x1560 or a group register.
- R6: A record is dropped and the error flag is set in any of these cases: the address lies outside every window and every slot; the count is greater than 2; a group value has any of bits 63:32 set; a device address has any bit at or above DEV_AW set. The records that follow are still applied.
- R7: A record with count 0 ends the task. It writes nothing, sets no error, and causes done_o to pulse for exactly one cycle.
- R8: If the end-of-stream strobe arrives on byte 43, the record is applied and the task ends. If it arrives on any earlier byte, the partial record is dropped, the error flag is set, and the task ends.
- R9: Once set, err_o stays high through done_o. It is cleared when the first byte of the next task is accepted.
- R10: s_ready_o is high after reset. It drops for exactly one cycle after the byte that ends a task is accepted.
- R11: A read returns a value two clock edges after rd_addr_i is applied. A group value is zero-extended to DEV_AW bits. An address that matches no window or slot reads 0.
- R12: After reset, done_o and err_o are 0 and every register reads its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Loader accepts a byte |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | End-of-stream strobe on this byte |
| rd_addr_i | input | 16 | Register address to inspect |
| rd_data_o | output | DEV_AW | Register or base value, two edges after the address |
| done_o | output | 1 | One-cycle task completion pulse |
| err_o | output | 1 | Sticky dropped-record flag |

## Verification
The main table task mixes several record types in one stream: single group writes at the first and last address of a window, a repeated write to the same register, single DMA base writes, and paired DMA writes. A read of every window edge and every slot then confirms three things: values land in the right place, padding bytes have no effect, and untouched registers keep their defaults. A second task places each rejected record shape next to a valid record. This shows that a drop affects only the offending record and that the error flag stays set while the valid records are still applied. Further tasks check three more behaviours: a terminator-only task clears the error flag and restores the previous task's registers to their defaults; a record cut short by the strobe is dropped; and the strobe on a full record both applies it and ends the task.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int NUM_GRP = 6;
  localparam int NUM_DMA = 7;
  localparam int SLOT_W  = $clog2(NUM_DMA);

  // window bases; layout of the image memory follows this order
  localparam logic [15:0] GRP_BASE [NUM_GRP] = '{
    16'h4100, 16'h4500, 16'h4900, 16'h4D00, 16'h5100, 16'h5500
  };

  // slot order matters: a paired record spills into the next slot
  localparam logic [15:0] DMA_ADDR [NUM_DMA] = '{
    16'h1344, 16'h134A, 16'h1442, 16'h1554, 16'h1558, 16'h155C, 16'h1560
  };

  localparam logic [15:0] DFLT_TAG = 16'hD5F0;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_GRP  = 2'd1,
    K_DMA  = 2'd2
  } kind_e;

  function automatic logic [31:0] grp_default(input logic [15:0] a);
    return {DFLT_TAG, a};
  endfunction
endpackage

// File: rtl/rsl_deframer.sv
module rsl_deframer #(
  parameter int REC_BYTES = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_i,
  input  logic [7:0]   s_data_i,
  input  logic         s_last_i,
  output logic         end_o,
  output logic         rec_vld_o,
  output logic         rec_trunc_o,
  output logic         rec_end_o,
  output logic [191:0] hdr_o
);
  localparam int HDR_BYTES = 24;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int IDX_W     = $clog2(REC_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic [HDR_W-1:0] hdr_q;
  logic             last_byte;

  assign last_byte = (idx_q == IDX_W'(REC_BYTES - 1));
  // a task ends on the strobe or on a complete zero-count record
  assign end_o = take_i && (s_last_i || (last_byte && hdr_q[31:0] == 32'd0));
  assign hdr_o = hdr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      hdr_q       <= '0;
      rec_vld_o   <= 1'b0;
      rec_trunc_o <= 1'b0;
      rec_end_o   <= 1'b0;
    end else begin
      rec_vld_o <= 1'b0;
      if (take_i) begin
        if (idx_q < IDX_W'(HDR_BYTES)) hdr_q <= {s_data_i, hdr_q[HDR_W-1:8]};
        if (last_byte || s_last_i) begin
          idx_q       <= '0;
          rec_vld_o   <= 1'b1;
          rec_trunc_o <= !last_byte;
          rec_end_o   <= end_o;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  p_idx_range_r1: assert property (@(posedge clk) disable iff (rst)
    idx_q < IDX_W'(REC_BYTES));

  p_trunc_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_vld_o && rec_trunc_o) |-> $past(take_i && s_last_i));
endmodule

// File: rtl/rsl_addr_decode.sv
module rsl_addr_decode
  import rsl_pkg::*;
#(
  parameter int GRP_REGS = 16,
  localparam int DEPTH   = NUM_GRP * GRP_REGS,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic [31:0]       addr_i,
  output kind_e             kind_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [NUM_GRP-1:0] ghit;
  logic [15:0]        goff [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_win
    assign goff[g] = addr_i[15:0] - GRP_BASE[g];
    assign ghit[g] = (addr_i[31:16] == 16'h0) &&
                     (addr_i[15:0] >= GRP_BASE[g]) &&
                     (goff[g] < 16'(GRP_REGS));
  end

  always_comb begin
    kind_o = K_NONE;
    idx_o  = '0;
    slot_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (ghit[g]) begin
        kind_o = K_GRP;
        idx_o  = IDX_W'(g * GRP_REGS) + IDX_W'(goff[g]);
      end
    end
    for (int s = 0; s < NUM_DMA; s++) begin
      if (addr_i == {16'h0, DMA_ADDR[s]}) begin
        kind_o = K_DMA;
        slot_o = SLOT_W'(s);
      end
    end
  end
endmodule

// File: rtl/rsl_reg_image.sv
module rsl_reg_image
  import rsl_pkg::*;
#(
  parameter int GRP_REGS = 16,
  parameter int DEV_AW   = 40,
  localparam int DEPTH   = NUM_GRP * GRP_REGS,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_grp_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic              wr_dma0_i,
  input  logic              wr_dma1_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DEV_AW-1:0] wr_addr0_i,
  input  logic [DEV_AW-1:0] wr_addr1_i,
  input  kind_e             rd_kind_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [15:0]       rd_addr_i,
  output logic [DEV_AW-1:0] rd_data_o
);
  logic [31:0]       mem [DEPTH];
  logic [31:0]       mem_q;
  logic [DEPTH-1:0]  dirty_q;
  logic [DEV_AW-1:0] dma_q [NUM_DMA];

  kind_e             kind1_q;
  logic              dirty1_q;
  logic [31:0]       dflt1_q;
  logic [DEV_AW-1:0] dma1_q;

  // data array: no reset, single write and single read port
  always_ff @(posedge clk) begin
    if (wr_grp_i) mem[wr_idx_i] <= wr_data_i;
    mem_q <= mem[rd_idx_i];
  end

  // written-this-task flags stand in for reloading the default image
  always_ff @(posedge clk) begin
    if (rst || clr_i)  dirty_q <= '0;
    else if (wr_grp_i) dirty_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int s = 0; s < NUM_DMA; s++) dma_q[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_DMA; s++) begin
        if (wr_dma0_i && wr_slot_i == SLOT_W'(s))
          dma_q[s] <= wr_addr0_i;
        else if (wr_dma1_i && s > 0 && wr_slot_i == SLOT_W'(s - 1))
          dma_q[s] <= wr_addr1_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind1_q   <= K_NONE;
      dirty1_q  <= 1'b0;
      dflt1_q   <= '0;
      dma1_q    <= '0;
      rd_data_o <= '0;
    end else begin
      kind1_q  <= rd_kind_i;
      dirty1_q <= dirty_q[rd_idx_i];
      dflt1_q  <= grp_default(rd_addr_i);
      dma1_q   <= dma_q[rd_slot_i];
      case (kind1_q)
        K_GRP:   rd_data_o <= dirty1_q ? DEV_AW'(mem_q) : DEV_AW'(dflt1_q);
        K_DMA:   rd_data_o <= dma1_q;
        default: rd_data_o <= '0;
      endcase
    end
  end

  p_write_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_grp_i, wr_dma0_i}));

  p_pair_has_successor_r5: assert property (@(posedge clk) disable iff (rst)
    wr_dma1_i |-> (wr_dma0_i && wr_slot_i != SLOT_W'(NUM_DMA - 1)));

  p_clear_alone_r3: assert property (@(posedge clk) disable iff (rst)
    clr_i |-> !(wr_grp_i || wr_dma0_i));
endmodule

// File: rtl/regstream_loader.sv
module regstream_loader
  import rsl_pkg::*;
#(
  parameter int GRP_REGS  = 16,
  parameter int DEV_AW    = 40,
  parameter int REC_BYTES = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  input  logic [15:0]       rd_addr_i,
  output logic [DEV_AW-1:0] rd_data_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int DEPTH = NUM_GRP * GRP_REGS;
  localparam int IDX_W = $clog2(DEPTH);

  logic              take, end_w, task_start, in_task_q;
  logic              rec_vld, rec_trunc, rec_end;
  logic [191:0]      hdr;
  logic [31:0]       cnt, raddr;
  logic [63:0]       val0, val1;
  kind_e             wkind, rkind;
  logic [IDX_W-1:0]  widx, ridx;
  logic [SLOT_W-1:0] wslot, rslot;
  logic              rec_ok, cnt_zero, cnt_one, cnt_two;
  logic              v0_fit_grp, v0_fit_dma, v1_fit_dma, pair_ok;
  logic              wr_grp, wr_dma0, wr_dma1, bad;

  assign take       = s_valid_i && s_ready_o;
  assign task_start = take && !in_task_q;

  rsl_deframer #(.REC_BYTES(REC_BYTES)) u_deframer (
    .clk         (clk),
    .rst         (rst),
    .take_i      (take),
    .s_data_i    (s_data_i),
    .s_last_i    (s_last_i),
    .end_o       (end_w),
    .rec_vld_o   (rec_vld),
    .rec_trunc_o (rec_trunc),
    .rec_end_o   (rec_end),
    .hdr_o       (hdr)
  );

  assign cnt   = hdr[31:0];
  assign raddr = hdr[63:32];
  assign val0  = hdr[127:64];
  assign val1  = hdr[191:128];

  rsl_addr_decode #(.GRP_REGS(GRP_REGS)) u_wdec (
    .addr_i (raddr),
    .kind_o (wkind),
    .idx_o  (widx),
    .slot_o (wslot)
  );

  rsl_addr_decode #(.GRP_REGS(GRP_REGS)) u_rdec (
    .addr_i ({16'h0, rd_addr_i}),
    .kind_o (rkind),
    .idx_o  (ridx),
    .slot_o (rslot)
  );

  // record qualification
  assign rec_ok     = rec_vld && !rec_trunc;
  assign cnt_zero   = (cnt == 32'd0);
  assign cnt_one    = (cnt == 32'd1);
  assign cnt_two    = (cnt == 32'd2);
  assign v0_fit_grp = (val0[63:32] == '0);
  assign v0_fit_dma = (val0[63:DEV_AW] == '0);
  assign v1_fit_dma = (val1[63:DEV_AW] == '0);
  assign pair_ok    = cnt_two && v0_fit_dma && v1_fit_dma &&
                      (wslot != SLOT_W'(NUM_DMA - 1));

  assign wr_grp  = rec_ok && cnt_one && (wkind == K_GRP) && v0_fit_grp;
  assign wr_dma0 = rec_ok && (wkind == K_DMA) && ((cnt_one && v0_fit_dma) || pair_ok);
  assign wr_dma1 = rec_ok && (wkind == K_DMA) && pair_ok;
  assign bad     = rec_vld && (rec_trunc || (!cnt_zero && !wr_grp && !wr_dma0));

  rsl_reg_image #(.GRP_REGS(GRP_REGS), .DEV_AW(DEV_AW)) u_image (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (task_start),
    .wr_grp_i   (wr_grp),
    .wr_idx_i   (widx),
    .wr_data_i  (val0[31:0]),
    .wr_dma0_i  (wr_dma0),
    .wr_dma1_i  (wr_dma1),
    .wr_slot_i  (wslot),
    .wr_addr0_i (val0[DEV_AW-1:0]),
    .wr_addr1_i (val1[DEV_AW-1:0]),
    .rd_kind_i  (rkind),
    .rd_idx_i   (ridx),
    .rd_slot_i  (rslot),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_task_q <= 1'b0;
      s_ready_o <= 1'b1;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      if (take) in_task_q <= !end_w;
      // one idle cycle lets the last record land before the next task clears
      s_ready_o <= !(take && end_w);
      done_o    <= rec_vld && rec_end;
      if (bad)             err_o <= 1'b1;
      else if (task_start) err_o <= 1'b0;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_ready_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (take && end_w) |=> !s_ready_o);

  p_ready_return_r10: assert property (@(posedge clk) disable iff (rst)
    !s_ready_o |=> s_ready_o);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err_o && !task_start) |=> err_o);
endmodule

// File: tb/regstream_loader_test.sv
module regstream_loader_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [39:0] rd_data;
  logic        done, err;

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regstream_loader uut (
    .clk (clk), .rst (rst),
    .s_valid_i (s_valid), .s_ready_o (s_ready),
    .s_data_i (s_data), .s_last_i (s_last),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data),
    .done_o (done), .err_o (err)
  );

  // {count, address, first value, second value}
  localparam logic [103:0] VEC [8] = '{
    {8'd1, 16'h4100, 40'h00_1111_1111, 40'h0},
    {8'd1, 16'h410F, 40'h00_CAFE_BABE, 40'h0},
    {8'd1, 16'h550A, 40'h00_0BAD_F00D, 40'h0},
    {8'd2, 16'h1344, 40'h12_3456_7890, 40'hAB_CDEF_0123},
    {8'd1, 16'h1442, 40'h00_8000_0000, 40'h0},
    {8'd2, 16'h1558, 40'h55_5555_5555, 40'h66_6666_6666},
    {8'd1, 16'h4D03, 40'h00_0000_0001, 40'h0},
    {8'd1, 16'h4100, 40'h00_2222_2222, 40'h0}
  };
  localparam logic [15:0] SLOTS [7] = '{
    16'h1344, 16'h134A, 16'h1442, 16'h1554, 16'h1558, 16'h155C, 16'h1560
  };

  logic [31:0] m_grp [96];
  bit          m_dirty [96];
  logic [39:0] m_dma [7];

  function automatic int grp_index(input logic [15:0] a);
    for (int g = 0; g < 6; g++) begin
      int base = 'h4100 + g * 'h400;
      if (int'(a) >= base && int'(a) - base < 16) return g * 16 + (int'(a) - base);
    end
    return -1;
  endfunction

  function automatic int slot_index(input logic [15:0] a);
    for (int s = 0; s < 7; s++) if (SLOTS[s] == a) return s;
    return -1;
  endfunction

  function automatic logic [39:0] expect_rd(input logic [15:0] a);
    int gi = grp_index(a);
    int si = slot_index(a);
    if (gi >= 0) return m_dirty[gi] ? {8'h0, m_grp[gi]} : {8'h0, 16'hD5F0, a};
    if (si >= 0) return m_dma[si];
    return '0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 96; i++) m_dirty[i] = 0;
    for (int s = 0; s < 7; s++) m_dma[s] = '0;
  endtask

  task automatic model_apply(input int c, input logic [15:0] a,
                             input logic [39:0] v0, input logic [39:0] v1);
    int gi = grp_index(a);
    int si = slot_index(a);
    if (c == 1 && gi >= 0) begin m_grp[gi] = v0[31:0]; m_dirty[gi] = 1; end
    if (si >= 0) m_dma[si] = v0;
    if (c == 2 && si >= 0) m_dma[si + 1] = v1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit l);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = b; s_last = l;
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_rec(input logic [31:0] c, input logic [31:0] a,
                          input logic [63:0] v0, input logic [63:0] v1,
                          input bit eos, input int nbytes);
    logic [191:0] h = {v1, v0, a, c};
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = (i < 24) ? h[i*8 +: 8] : (8'hA5 ^ 8'(i));
      put(b, eos && (i == nbytes - 1));
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [39:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    logic [39:0] d;
    rd(a, d);
    chk(req, {24'h0, d}, {24'h0, expect_rd(a)});
  endtask

  // called right after the task-ending byte was accepted
  task automatic finish_task(input bit exp_err);
    chk("R10 ready low after ending byte", {63'h0, s_ready}, 64'h0);
    @(posedge clk); #1;
    chk("R7 done pulse", {63'h0, done}, 64'h1);
    chk("R9 error flag at done", {63'h0, err}, {63'h0, exp_err});
    chk("R10 ready back", {63'h0, s_ready}, 64'h1);
    @(posedge clk); #1;
    chk("R7 done one cycle", {63'h0, done}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] offs [4] = '{16'h0, 16'h3, 16'hA, 16'hF};
    logic [15:0] misc [4] = '{16'h0000, 16'h4110, 16'h40FF, 16'h5510};
    model_clear();
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R12 reset state
    chk("R12 done after reset", {63'h0, done}, 64'h0);
    chk("R12 err after reset", {63'h0, err}, 64'h0);
    chk("R10 ready after reset", {63'h0, s_ready}, 64'h1);
    rd_chk("R12 group default", 16'h4100);
    rd_chk("R12 group default", 16'h550F);
    rd_chk("R12 base default", 16'h134A);

    // task A: vector table walk (R1 R2 R4 R5), terminator (R7)
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c; logic [15:0] a; logic [39:0] v0, v1;
      {c, a, v0, v1} = VEC[i];
      send_rec({24'h0, c}, {16'h0, a}, {24'h0, v0}, {24'h0, v1}, 1'b0, 44);
      model_apply(int'(c), a, v0, v1);
    end
    send_rec(32'd0, 32'h0000_4100, 64'h0, 64'h0, 1'b0, 44);
    finish_task(1'b0);
    for (int g = 0; g < 6; g++)
      for (int k = 0; k < 4; k++)
        rd_chk("R2 group image", 16'h4100 + 16'(g) * 16'h400 + offs[k]);
    for (int s = 0; s < 7; s++) rd_chk("R5 base image", SLOTS[s]);
    for (int k = 0; k < 4; k++) rd_chk("R11 unmapped read", misc[k]);

    // task B: dropped records among good ones (R6 R5 R8 R9 R3)
    model_clear();
    send_rec(32'd1, 32'h0000_4504, 64'h1234, 64'h0, 1'b0, 44);
    model_apply(1, 16'h4504, 40'h1234, 40'h0);
    send_rec(32'd1, 32'h0000_4110, 64'h5, 64'h0, 1'b0, 44);
    send_rec(32'd3, 32'h0000_4900, 64'h5, 64'h0, 1'b0, 44);
    send_rec(32'd2, 32'h0000_4100, 64'h5, 64'h6, 1'b0, 44);
    send_rec(32'd2, 32'h0000_1560, 64'h5, 64'h6, 1'b0, 44);
    send_rec(32'd1, 32'h0000_4901, 64'h1_0000_0005, 64'h0, 1'b0, 44);
    send_rec(32'd1, 32'h0000_1442, 64'h100_0000_0000, 64'h0, 1'b0, 44);
    send_rec(32'd1, 32'h0001_4100, 64'h5, 64'h0, 1'b0, 44);
    send_rec(32'd1, 32'h0000_5101, 64'h77, 64'h0, 1'b1, 44);
    model_apply(1, 16'h5101, 40'h77, 40'h0);
    finish_task(1'b1);
    rd_chk("R8 strobe record applied", 16'h5101);
    rd_chk("R6 good record kept", 16'h4504);
    rd_chk("R6 count3 dropped", 16'h4900);
    rd_chk("R5 pair at group dropped", 16'h4100);
    rd_chk("R5 pair at last slot dropped", 16'h1560);
    rd_chk("R6 wide group value dropped", 16'h4901);
    rd_chk("R6 wide address dropped", 16'h1442);
    rd_chk("R3 previous task base reset", 16'h1344);
    rd_chk("R3 previous task group reset", 16'h410F);

    // task C: terminator only clears the error and the image (R9 R3)
    model_clear();
    send_rec(32'd0, 32'h0, 64'h0, 64'h0, 1'b0, 44);
    finish_task(1'b0);
    rd_chk("R3 group back to default", 16'h4504);
    rd_chk("R3 group back to default", 16'h5101);

    // task D: record cut by the strobe (R8)
    model_clear();
    send_rec(32'd1, 32'h0000_4100, 64'h99, 64'h0, 1'b1, 10);
    finish_task(1'b1);
    rd_chk("R8 partial record dropped", 16'h4100);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule